// File: doc/BRIEF.md
# Burst SDRAM Command Tracker

This block watches the command stream of a four-bank, burst-oriented SDRAM, one command per rising clock edge, and keeps a live picture of what the memory is doing. It records which banks have a row open and which row that is. It generates the column address of every beat of the running read or write burst. It raises a one-cycle error pulse whenever a command breaks the protocol rules.

A controller or a protocol monitor drives it with the same command, bank, address and auto-precharge signals that go to the memory. The burst length is programmed through a separate load strobe. The block honours the rules that matter for bursts. A new access may cut off a running burst on any cycle. A terminate is legal only for a read burst that has no auto-precharge. A burst issued with auto-precharge closes its bank by itself when it runs to completion.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A synchronous active-low reset closes every bank, stops any burst, clears the error output and sets the burst length to 4. A burst started after reset therefore lasts 4 cycles.
- R2: An ACTIVE (code 1) to a closed bank opens it and stores addr_i as that bank's row. From the next cycle the row appears on open_row_o, slice bank*ADDR_W.
- R3: A READ (code 2) or WRITE (code 3) to an open bank starts a burst. In the next cycle col_vld_o is 1, col_o holds addr_i[COL_W-1:0], and burst_wr_o is 1 for a WRITE and 0 for a READ.
- R4: bl_load_i with bl_code_i of 1, 2 or 3 sets the burst length to 2, 4 or 8. Code 0 keeps the current length. The new length applies to bursts started in later cycles. A burst keeps col_vld_o high for exactly its length in cycles.
- R5: Each beat advances the column by one, but only in the low log2(length) bits. The column wraps inside its aligned block and the upper bits never change.
- R6: A burst started with ap_i set closes its bank when it completes on its own. bank_open_o drops in the same cycle that col_vld_o falls.
- R7: A READ or WRITE issued while a burst runs replaces it at once, with no alignment rule. The cut-off burst performs no auto-precharge.
- R8: A BURST TERMINATE (code 5) during a read burst without auto-precharge ends it, so col_vld_o is 0 in the next cycle and no error is raised.
- R9: A BURST TERMINATE during a write burst, during an auto-precharge read burst, or with no burst running pulses err_o for one cycle. Any running burst continues unchanged.
- R10: A READ or WRITE to a closed bank, an ACTIVE to an open bank, or command code 6 or 7 pulses err_o for one cycle. The command changes no bank, row or burst state.
- R11: PRECHARGE (code 4) closes the selected bank, or every bank when addr_i[10] is 1. It cancels a burst running to a bank it closes. A PRECHARGE to a closed bank raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST TERMINATE |
| bank_i | input | BANK_W (2) | Bank select |
| addr_i | input | ADDR_W (13) | Row for ACTIVE, start column for READ/WRITE, bit 10 selects all banks for PRECHARGE |
| ap_i | input | 1 | Auto-precharge request with READ/WRITE |
| bl_load_i | input | 1 | Load strobe for the burst length |
| bl_code_i | input | 2 | Burst length code: 1=2, 2=4, 3=8, 0=keep |
| bank_open_o | output | NUM_BANKS (4) | One bit per bank, 1 when a row is open |
| open_row_o | output | NUM_BANKS*ADDR_W (52) | Stored row of each bank, bank b in slice b*ADDR_W |
| col_o | output | COL_W (10) | Column of the current burst beat |
| col_vld_o | output | 1 | High while a burst beat is presented |
| burst_wr_o | output | 1 | 1 when the running burst is a write |
| err_o | output | 1 | One-cycle pulse for an illegal command |

## Verification
Every output comes from a register. A command applied before rising edge N therefore shows its effect, whether a bank change, a new column, a terminated burst or an error pulse, in the cycle that follows edge N and not earlier. Burst beats advance one per edge after that. An auto-precharge close lands on the same edge where the valid strobe falls. The bench changes inputs on the falling edge and compares the vector's expected outputs on the next falling edge, one rising edge later. Burst-length checks count falling edges while the strobe stays high.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } cmd_e;

    localparam int DEF_BANKS   = 4;
    localparam int DEF_ADDR_W  = 13;
    localparam int DEF_COL_W   = 10;
    localparam int DEF_ALL_BIT = 10;
    localparam int DEF_MAX_LG  = 3;

endpackage

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
    import sdt_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  logic [2:0]    cmd,
    input  logic [BW-1:0] bank,
    input  logic          all_bit,
    input  logic [NB-1:0] open,
    input  logic          burst_act,
    input  logic          burst_wr,
    input  logic          burst_ap,
    output logic          act_go,
    output logic          acc_go,
    output logic          acc_wr,
    output logic          term_go,
    output logic [NB-1:0] pre_mask,
    output logic          err
);

    always_comb begin
        act_go   = 1'b0;
        acc_go   = 1'b0;
        acc_wr   = 1'b0;
        term_go  = 1'b0;
        pre_mask = '0;
        err      = 1'b0;
        case (cmd_e'(cmd))
            CMD_NOP: ;
            CMD_ACT: begin
                if (open[bank]) err = 1'b1;
                else            act_go = 1'b1;
            end
            CMD_RD, CMD_WR: begin
                if (!open[bank]) begin
                    err = 1'b1;
                end else begin
                    acc_go = 1'b1;
                    acc_wr = (cmd == CMD_WR);
                end
            end
            CMD_PRE: begin
                if (all_bit) pre_mask = '1;
                else         pre_mask = NB'(1) << bank;
            end
            CMD_BST: begin
                if (burst_act && !burst_wr && !burst_ap) term_go = 1'b1;
                else                                     err = 1'b1;
            end
            default: err = 1'b1;
        endcase
    end

endmodule

// File: rtl/sdt_bank_table.sv
module sdt_bank_table #(
    parameter int NB = 4,
    parameter int BW = 2,
    parameter int RW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act_go,
    input  logic [BW-1:0]  act_bank,
    input  logic [RW-1:0]  act_row,
    input  logic [NB-1:0]  close_mask,
    output logic [NB-1:0]  open_o,
    output logic [NB*RW-1:0] rows_o
);

    typedef struct packed {
        logic          open;
        logic [RW-1:0] row;
    } bank_t;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        bank_t b_d, b_q;

        always_comb begin
            b_d = b_q;
            if (close_mask[g]) b_d.open = 1'b0;
            if (act_go && act_bank == BW'(g)) begin
                b_d.open = 1'b1;
                b_d.row  = act_row;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= b_d;
        end

        assign open_o[g]          = b_q.open;
        assign rows_o[g*RW +: RW] = b_q.row;

        // R2: a bank only becomes open through an accepted ACTIVE to it
        a_r2_open_by_act: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(open_o[g]) |-> $past(act_go && act_bank == BW'(g)));

        // R10: an open bank keeps its row while it stays open
        a_r10_row_held: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(open_o[g]) && open_o[g]) |-> $stable(rows_o[g*RW +: RW]));
    end

endmodule

// File: rtl/sdt_burst.sv
module sdt_burst #(
    parameter int NB    = 4,
    parameter int BW    = 2,
    parameter int CW    = 10,
    parameter int MAXLG = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bl_load,
    input  logic [1:0]    bl_code,
    input  logic          start,
    input  logic          start_wr,
    input  logic          start_ap,
    input  logic [BW-1:0] start_bank,
    input  logic [CW-1:0] start_col,
    input  logic          term,
    input  logic [NB-1:0] cancel_mask,
    output logic          act_o,
    output logic          wr_o,
    output logic          ap_o,
    output logic [CW-1:0] col_o,
    output logic [NB-1:0] ap_close_o
);

    localparam int RMW = MAXLG;

    typedef struct packed {
        logic           act;
        logic           wr;
        logic           ap;
        logic [BW-1:0]  bank;
        logic [CW-1:0]  col;
        logic [RMW-1:0] rem;
        logic [RMW-1:0] mask;
        logic [1:0]     lg;
    } burst_t;

    burst_t s_d, s_q;
    logic   ending, cut;
    logic [CW-1:0] wmask;

    function automatic logic [RMW-1:0] len_mask(input logic [1:0] lg);
        return RMW'((1 << lg) - 1);
    endfunction

    always_comb begin
        s_d        = s_q;
        ap_close_o = '0;
        ending     = s_q.act && (s_q.rem == '0);
        cut        = term || cancel_mask[s_q.bank];
        wmask      = {{(CW-RMW){1'b0}}, s_q.mask};
        if (bl_load && bl_code != 2'd0) s_d.lg = bl_code;
        if (start) begin
            s_d.act  = 1'b1;
            s_d.wr   = start_wr;
            s_d.ap   = start_ap;
            s_d.bank = start_bank;
            s_d.col  = start_col;
            s_d.mask = len_mask(s_q.lg);
            s_d.rem  = len_mask(s_q.lg);
        end else if (s_q.act) begin
            if (cut || ending) begin
                s_d.act = 1'b0;
                if (ending && !cut && s_q.ap) ap_close_o = NB'(1) << s_q.bank;
            end else begin
                s_d.rem = s_q.rem - 1'b1;
                s_d.col = (s_q.col & ~wmask) | ((s_q.col + 1'b1) & wmask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.lg <= 2'd2;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o = s_q.act;
    assign wr_o  = s_q.wr;
    assign ap_o  = s_q.ap;
    assign col_o = s_q.col;

    // R5: continuing beats never change the column bits above the burst block
    a_r5_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act_o) && act_o && !$past(start)) |-> ((col_o >> MAXLG) == ($past(col_o) >> MAXLG)));

    // R8: an accepted terminate leaves no beat in the next cycle
    a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !act_o);

    // R3: a start always presents its column in the next cycle
    a_r3_start_col: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (act_o && col_o == $past(start_col)));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdt_pkg::*;
#(
    parameter int NUM_BANKS = DEF_BANKS,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int COL_W     = DEF_COL_W,
    parameter int ALL_BIT   = DEF_ALL_BIT,
    parameter int MAX_LG    = DEF_MAX_LG,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  cmd_i,
    input  logic [BANK_W-1:0]           bank_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        ap_i,
    input  logic                        bl_load_i,
    input  logic [1:0]                  bl_code_i,
    output logic [NUM_BANKS-1:0]        bank_open_o,
    output logic [NUM_BANKS*ADDR_W-1:0] open_row_o,
    output logic [COL_W-1:0]            col_o,
    output logic                        col_vld_o,
    output logic                        burst_wr_o,
    output logic                        err_o
);

    typedef struct packed {
        logic err;
    } top_t;

    top_t t_d, t_q;

    logic                 act_go, acc_go, acc_wr, term_go, err_now;
    logic [NUM_BANKS-1:0] pre_mask, ap_close, close_mask;
    logic                 b_act, b_wr, b_ap;

    sdt_cmd_decode #(.NB(NUM_BANKS), .BW(BANK_W)) i_dec (
        .cmd       (cmd_i),
        .bank      (bank_i),
        .all_bit   (addr_i[ALL_BIT]),
        .open      (bank_open_o),
        .burst_act (b_act),
        .burst_wr  (b_wr),
        .burst_ap  (b_ap),
        .act_go    (act_go),
        .acc_go    (acc_go),
        .acc_wr    (acc_wr),
        .term_go   (term_go),
        .pre_mask  (pre_mask),
        .err       (err_now)
    );

    sdt_burst #(.NB(NUM_BANKS), .BW(BANK_W), .CW(COL_W), .MAXLG(MAX_LG)) i_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .bl_load     (bl_load_i),
        .bl_code     (bl_code_i),
        .start       (acc_go),
        .start_wr    (acc_wr),
        .start_ap    (ap_i),
        .start_bank  (bank_i),
        .start_col   (addr_i[COL_W-1:0]),
        .term        (term_go),
        .cancel_mask (pre_mask),
        .act_o       (b_act),
        .wr_o        (b_wr),
        .ap_o        (b_ap),
        .col_o       (col_o),
        .ap_close_o  (ap_close)
    );

    assign close_mask = pre_mask | ap_close;

    sdt_bank_table #(.NB(NUM_BANKS), .BW(BANK_W), .RW(ADDR_W)) i_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_go     (act_go),
        .act_bank   (bank_i),
        .act_row    (addr_i),
        .close_mask (close_mask),
        .open_o     (bank_open_o),
        .rows_o     (open_row_o)
    );

    always_comb begin
        t_d     = t_q;
        t_d.err = err_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign col_vld_o  = b_act;
    assign burst_wr_o = b_wr;
    assign err_o      = t_q.err;

    // R10: access to a closed bank is reported one cycle later
    a_r10_closed_access: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !bank_open_o[bank_i]) |=> err_o);

    // R11: precharge-all leaves every bank closed and no burst running
    a_r11_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && addr_i[ALL_BIT]) |=> (bank_open_o == '0 && !col_vld_o));

    // R6: an auto-precharge completion closes its bank
    a_r6_ap_close: assert property (@(posedge clk) disable iff (!rst_n)
        (|ap_close) |=> ((bank_open_o & $past(ap_close)) == '0));

    // R9: a terminate during a write burst is an error
    a_r9_bst_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_BST && col_vld_o && burst_wr_o) |=> err_o);

endmodule

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int N = 42;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

    // inputs {cmd, bank, addr, ap, load, code} then expected {open, vld, col, wr, err}
    localparam logic [38:0] VEC [N] = '{
        {ACT,2'd0,13'h012,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 0  R2
        {ACT,2'd1,13'h034,1'b0,1'b0,2'd0, 4'b0011,1'b0,10'h000,1'b0,1'b0}, // 1  R2
        {RD ,2'd0,13'h006,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h006,1'b0,1'b0}, // 2  R3
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h007,1'b0,1'b0}, // 3  R5
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h004,1'b0,1'b0}, // 4  R5 wrap
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h005,1'b0,1'b0}, // 5  R4
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b0,10'h000,1'b0,1'b0}, // 6  R4 ends
        {NOP,2'd0,13'h000,1'b0,1'b1,2'd3, 4'b0011,1'b0,10'h000,1'b0,1'b0}, // 7  R4 load 8
        {WR ,2'd1,13'h00D,1'b1,1'b0,2'd0, 4'b0011,1'b1,10'h00D,1'b1,1'b0}, // 8  R3
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h00E,1'b1,1'b0}, // 9  R5
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h00F,1'b1,1'b0}, // 10 R5
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h008,1'b1,1'b0}, // 11 R5 wrap
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h009,1'b1,1'b0}, // 12 R4
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h00A,1'b1,1'b0}, // 13 R4
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h00B,1'b1,1'b0}, // 14 R4
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0011,1'b1,10'h00C,1'b1,1'b0}, // 15 R4
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 16 R6
        {BST,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b1}, // 17 R9 idle
        {NOP,2'd0,13'h000,1'b0,1'b1,2'd1, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 18 R4 load 2
        {RD ,2'd0,13'h3FE,1'b0,1'b0,2'd0, 4'b0001,1'b1,10'h3FE,1'b0,1'b0}, // 19 R4
        {WR ,2'd0,13'h101,1'b0,1'b0,2'd0, 4'b0001,1'b1,10'h101,1'b1,1'b0}, // 20 R7
        {BST,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b1,10'h100,1'b1,1'b1}, // 21 R9 write
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 22 R4
        {RD ,2'd0,13'h002,1'b0,1'b0,2'd0, 4'b0001,1'b1,10'h002,1'b0,1'b0}, // 23 R3
        {BST,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 24 R8
        {RD ,2'd3,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b1}, // 25 R10
        {ACT,2'd0,13'h055,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b1}, // 26 R10
        {3'd6,2'd0,13'h000,1'b0,1'b0,2'd0,4'b0001,1'b0,10'h000,1'b0,1'b1}, // 27 R10
        {ACT,2'd2,13'h001,1'b0,1'b0,2'd0, 4'b0101,1'b0,10'h000,1'b0,1'b0}, // 28 R2
        {RD ,2'd2,13'h004,1'b1,1'b0,2'd0, 4'b0101,1'b1,10'h004,1'b0,1'b0}, // 29 R3
        {BST,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0101,1'b1,10'h005,1'b0,1'b1}, // 30 R9 ap read
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 31 R6
        {ACT,2'd2,13'h001,1'b0,1'b0,2'd0, 4'b0101,1'b0,10'h000,1'b0,1'b0}, // 32 R2
        {RD ,2'd2,13'h008,1'b0,1'b0,2'd0, 4'b0101,1'b1,10'h008,1'b0,1'b0}, // 33 R3
        {PRE,2'd2,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 34 R11
        {PRE,2'd0,13'h400,1'b0,1'b0,2'd0, 4'b0000,1'b0,10'h000,1'b0,1'b0}, // 35 R11 all
        {PRE,2'd3,13'h000,1'b0,1'b0,2'd0, 4'b0000,1'b0,10'h000,1'b0,1'b0}, // 36 R11 closed
        {ACT,2'd0,13'h0AB,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}, // 37 R2
        {RD ,2'd0,13'h000,1'b1,1'b0,2'd0, 4'b0001,1'b1,10'h000,1'b0,1'b0}, // 38 R3
        {RD ,2'd0,13'h004,1'b0,1'b0,2'd0, 4'b0001,1'b1,10'h004,1'b0,1'b0}, // 39 R7 cut
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b1,10'h005,1'b0,1'b0}, // 40 R7
        {NOP,2'd0,13'h000,1'b0,1'b0,2'd0, 4'b0001,1'b0,10'h000,1'b0,1'b0}  // 41 R7 no ap
    };

    localparam int TAG [N] = '{2,2,3,5,5,4,4,4,3,5,5,5,4,4,4,4,6,9,4,4,7,9,4,3,8,10,10,10,
                               2,3,9,6,2,3,11,11,11,2,3,7,7,7};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = '0;
    logic [1:0]  bank_i = '0;
    logic [12:0] addr_i = '0;
    logic        ap_i = 1'b0;
    logic        bl_load_i = 1'b0;
    logic [1:0]  bl_code_i = '0;
    logic [3:0]  bank_open_o;
    logic [51:0] open_row_o;
    logic [9:0]  col_o;
    logic        col_vld_o, burst_wr_o, err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker i_sdram_cmd_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd_i),
        .bank_i      (bank_i),
        .addr_i      (addr_i),
        .ap_i        (ap_i),
        .bl_load_i   (bl_load_i),
        .bl_code_i   (bl_code_i),
        .bank_open_o (bank_open_o),
        .open_row_o  (open_row_o),
        .col_o       (col_o),
        .col_vld_o   (col_vld_o),
        .burst_wr_o  (burst_wr_o),
        .err_o       (err_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a,
                         input logic p, input logic l, input logic [1:0] lc);
        cmd_i = c; bank_i = b; addr_i = a; ap_i = p; bl_load_i = l; bl_code_i = lc;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        chk("R1", "reset state", {bank_open_o, col_vld_o, err_o}, '0);

        for (int i = 0; i < N; i++) begin
            logic [38:0] v;
            logic [16:0] got, exp;
            v = VEC[i];
            drive(v[38:36], v[35:34], v[33:21], v[20], v[19], v[18:17]);
            @(negedge clk);
            exp = v[16:0];
            got = {bank_open_o, col_vld_o, (exp[12] ? col_o : 10'h000), (exp[12] ? burst_wr_o : 1'b0), err_o};
            chk($sformatf("R%0d", TAG[i]), $sformatf("vector %0d", i), 32'(got), 32'(exp));
        end
        drive(NOP, 2'd0, 13'h000, 1'b0, 1'b0, 2'd0);

        // R2: stored row of bank 0
        chk("R2", "row bank0", 32'(open_row_o[12:0]), 32'h0AB);

        // R10: ACTIVE to an open bank leaves its row untouched
        drive(ACT, 2'd0, 13'h1FF, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        chk("R10", "err on reopen", 32'(err_o), 32'd1);
        drive(NOP, 2'd0, 13'h000, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        chk("R10", "row kept", 32'(open_row_o[12:0]), 32'h0AB);

        // R1: mid-run reset with a burst running, then default length 4
        drive(RD, 2'd0, 13'h000, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        drive(NOP, 2'd0, 13'h000, 1'b0, 1'b1, 2'd3);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(NOP, 2'd0, 13'h000, 1'b0, 1'b0, 2'd0);
        chk("R1", "mid reset", {bank_open_o, col_vld_o, err_o}, '0);
        drive(ACT, 2'd1, 13'h077, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        drive(RD, 2'd1, 13'h001, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        drive(NOP, 2'd0, 13'h000, 1'b0, 1'b0, 2'd0);
        begin
            int beats = 0;
            for (int k = 0; k < 12; k++) begin
                if (col_vld_o) beats++;
                @(negedge clk);
            end
            chk("R1", "default burst length", 32'(beats), 32'd4);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule